// File: doc/BRIEF.md
# Coherent Store Buffer

This block holds the stores of one out-of-order core between issue and their write into the private cache. The core runs in a snooping multiprocessor with an invalidation-based protocol. Stores enter in program order with an address and data word. Each entry stays private to the core until the reorder buffer retires it. Younger loads probe the buffer and take the value of the youngest older store to the same word. When no entry matches, they fall back to the cache.

Only the oldest retired entry may commit. At commit the block reads the local MSI state of the target line, as it stands in that cycle. A line in M is written at once. A line in S first needs an upgrade request on the bus. An invalid line first needs a read-exclusive request. The request is held until the bus grants it. The grant moves the line to M and pulses the cache write strobe.

A small line-state table models the effect of remote snoops on the line state. Remote reads and read-exclusives can take a line away while stores to it still wait in the buffer. The cache array and the bus arbiter sit outside the block and are reached through simple strobes and a request/grant pair.

Top module: `stbuf_top`

## Requirements
- R1: `wr_en_o` is asserted only for the oldest buffered store, and only after `retire_i` has marked that store. `retire_i` marks the oldest unmarked entry and is ignored when every held entry is already marked. Stores reach the cache in program order.
- R2: Forwarding compares address bits [AW-1:2] (`ld_word_i`) against the entries from the head up to, but not including, the pointer `ld_age_i`. Among the matches, the youngest supplies `ld_data_o`. `ld_hit_o` is 0 when nothing matches, or when `ld_age_i` lies outside the range from the head to the tail.
- R3: If the line is in M when its retired head entry commits, `wr_en_o` rises in that same cycle and the entry is removed. No bus request is raised.
- R4: If the line is in S at commit, `bus_req_o` rises in the next cycle with `bus_req_type_o`=0 (upgrade). It stays high, with the address and type unchanged, until `bus_gnt_i`.
- R5: If the line is invalid at commit, the request uses `bus_req_type_o`=1 (read-exclusive) and otherwise behaves as in R4.
- R6: In a cycle where `bus_req_o` and `bus_gnt_i` are both high, `wr_en_o` pulses, the entry is removed and the line goes to M.
- R7: A snoop of type 0 (remote read) on a line in M sets `snp_supply_o` in that cycle and moves the line to S. Buffered store data is never written out by a snoop. The line index is address bits [OFF_W+IDX_W-1:OFF_W], which is [7:4] by default.
- R8: A snoop of type 1 (remote read-exclusive) sets `snp_supply_o` if the line is in M, and the line becomes invalid in every case.
- R9: Snoops do not change forwarding. A buffered store keeps forwarding to matching younger loads after its line is downgraded or invalidated.
- R10: A snoop in the same cycle as a commit decision is ordered first, so the decision uses the state after the snoop. A grant in the same cycle as a snoop to the same line leaves the line in M.
- R11: With DEPTH entries held, `st_ready_o` is 0 and `st_valid_i` is ignored.
- R12: `flush_i` drops every unretired entry in one cycle. A retire in the same cycle takes effect first. A store offered in the flush cycle is dropped. Retired entries stay, including one waiting for a grant. `st_tag_o` is the tail pointer, which has log2(DEPTH)+1 bits.
- R13: After reset the buffer is empty, every line is invalid, and no request or write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store offered for allocation |
| st_addr_i | input | AW | Store byte address |
| st_data_i | input | DW | Store data |
| st_ready_o | output | 1 | Buffer can accept a store |
| st_tag_o | output | log2(DEPTH)+1 | Current tail pointer (age tag for loads) |
| retire_i | input | 1 | Oldest unretired store has retired |
| flush_i | input | 1 | Discard all unretired stores |
| ld_word_i | input | AW-2 | Load word address |
| ld_age_i | input | log2(DEPTH)+1 | Tail pointer captured when the load was issued |
| ld_hit_o | output | 1 | Forwarded data valid; low means use the cache |
| ld_data_o | output | DW | Forwarded data |
| snp_valid_i | input | 1 | Remote snoop present |
| snp_type_i | input | 1 | 0 = remote read, 1 = remote read-exclusive |
| snp_idx_i | input | IDX_W | Snooped line index |
| snp_supply_o | output | 1 | This core sources the committed line |
| bus_req_o | output | 1 | Bus request pending |
| bus_req_type_o | output | 1 | 0 = upgrade, 1 = read-exclusive |
| bus_req_addr_o | output | AW | Address of the request |
| bus_gnt_i | input | 1 | Bus grant |
| wr_en_o | output | 1 | Cache write strobe |
| wr_addr_o | output | AW | Cache write address |
| wr_data_o | output | DW | Cache write data |

## Verification
The critical collision is a remote snoop that lands on the line of the retired head entry in the same cycle. That cycle may be the one in which the commit is decided, or the one in which the grant returns. The bench provokes it directly, with a remote read-exclusive aimed at an M line just as its head entry becomes eligible. It also provokes it at random, by drawing stores and snoops from only three lines so that they overlap often. A behavioural model applies the snoop first and then the commit. It is compared in every cycle on the write strobe, the request type and the supply flag, so the wrong ordering shows up as a missing or premature write or as the wrong request type.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_M = 2'd2} line_st_e;
  typedef enum logic {SNP_RD = 1'b0, SNP_RDX = 1'b1} snp_e;
  typedef enum logic {REQ_UPG = 1'b0, REQ_RDX = 1'b1} req_e;
  typedef enum logic {CM_IDLE = 1'b0, CM_WAIT = 1'b1} cm_e;
endpackage

// File: rtl/stbuf_queue.sv
module stbuf_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          retire_i,
  input  logic          flush_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic [PW-1:0] tail_o,
  output logic          head_ret_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  input  logic [AW-3:0] ld_word_i,
  input  logic [PW-1:0] ld_age_i,
  output logic          ld_hit_o,
  output logic [DW-1:0] ld_data_o
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q, rptr_q;
  logic [PW-1:0] used, span;
  logic          retire_ok, do_push;

  assign used       = tail_q - head_q;
  assign full_o     = used == PW'(DEPTH);
  assign tail_o     = tail_q;
  assign head_ret_o = rptr_q != head_q;
  assign head_addr_o = addr_q[IW'(head_q)];
  assign head_data_o = data_q[IW'(head_q)];
  assign retire_ok  = retire_i && (rptr_q != tail_q);
  assign do_push    = push_i && !full_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      rptr_q <= '0;
    end else begin
      if (pop_i)     head_q <= head_q + 1'b1;
      if (retire_ok) rptr_q <= rptr_q + 1'b1;
      // unretired entries are dropped; a same-cycle retire is kept
      if (flush_i)      tail_q <= rptr_q + PW'(retire_ok);
      else if (do_push) tail_q <= tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) begin
      addr_q[IW'(tail_q)] <= push_addr_i;
      data_q[IW'(tail_q)] <= push_data_i;
    end
  end

  // youngest older match wins: later iterations overwrite
  always_comb begin
    ld_hit_o  = 1'b0;
    ld_data_o = '0;
    span      = ld_age_i - head_q;
    if (span > used) span = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (PW'(i) < span && addr_q[IW'(head_q + PW'(i))][AW-1:2] == ld_word_i) begin
        ld_hit_o  = 1'b1;
        ld_data_o = data_q[IW'(head_q + PW'(i))];
      end
    end
  end

  // R11
  full_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i && !flush_i |=> tail_q == $past(tail_q));

  // R12
  flush_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> rptr_q == tail_q);
endmodule

// File: rtl/stbuf_lines.sv
module stbuf_lines
  import stbuf_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int NL   = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             snp_valid_i,
  input  snp_e             snp_type_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  output logic             supply_o,
  input  logic [IDX_W-1:0] look_idx_i,
  output line_st_e         look_st_o,
  input  logic             set_m_i,
  input  logic [IDX_W-1:0] set_idx_i
);
  line_st_e state_q [NL];
  line_st_e snp_nxt;

  always_comb begin
    snp_nxt = state_q[snp_idx_i];
    if (snp_type_i == SNP_RDX)          snp_nxt = LS_I;
    else if (state_q[snp_idx_i] == LS_M) snp_nxt = LS_S;
  end

  assign supply_o = snp_valid_i && state_q[snp_idx_i] == LS_M;
  // commit sees the state after a same-cycle snoop
  assign look_st_o = (snp_valid_i && snp_idx_i == look_idx_i) ? snp_nxt : state_q[look_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NL; i++) state_q[i] <= LS_I;
    end else begin
      if (snp_valid_i) state_q[snp_idx_i] <= snp_nxt;
      if (set_m_i)     state_q[set_idx_i] <= LS_M;
    end
  end

  // R7
  rd_to_s_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_type_i == SNP_RD && state_q[snp_idx_i] == LS_M &&
    !(set_m_i && set_idx_i == snp_idx_i) |=> state_q[$past(snp_idx_i)] == LS_S);

  // R8
  rdx_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_valid_i && snp_type_i == SNP_RDX &&
    !(set_m_i && set_idx_i == snp_idx_i) |=> state_q[$past(snp_idx_i)] == LS_I);
endmodule

// File: rtl/stbuf_top.sv
module stbuf_top
  import stbuf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 4,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_valid_i,
  input  logic [AW-1:0]    st_addr_i,
  input  logic [DW-1:0]    st_data_i,
  output logic             st_ready_o,
  output logic [PW-1:0]    st_tag_o,
  input  logic             retire_i,
  input  logic             flush_i,
  input  logic [AW-3:0]    ld_word_i,
  input  logic [PW-1:0]    ld_age_i,
  output logic             ld_hit_o,
  output logic [DW-1:0]    ld_data_o,
  input  logic             snp_valid_i,
  input  logic             snp_type_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  output logic             snp_supply_o,
  output logic             bus_req_o,
  output logic             bus_req_type_o,
  output logic [AW-1:0]    bus_req_addr_o,
  input  logic             bus_gnt_i,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [DW-1:0]    wr_data_o
);
  logic             full, head_ret, pop, set_m;
  logic [AW-1:0]    head_addr;
  logic [DW-1:0]    head_data;
  logic [IDX_W-1:0] head_idx;
  line_st_e         line_st;
  cm_e              cm_q, cm_d;
  req_e             rt_q, rt_d;

  stbuf_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
    .clk_i, .rst_ni,
    .push_i(st_valid_i), .push_addr_i(st_addr_i), .push_data_i(st_data_i),
    .retire_i, .flush_i, .pop_i(pop),
    .full_o(full), .tail_o(st_tag_o),
    .head_ret_o(head_ret), .head_addr_o(head_addr), .head_data_o(head_data),
    .ld_word_i, .ld_age_i, .ld_hit_o, .ld_data_o
  );

  assign head_idx = head_addr[OFF_W +: IDX_W];

  stbuf_lines #(.IDX_W(IDX_W)) u_lines (
    .clk_i, .rst_ni,
    .snp_valid_i, .snp_type_i(snp_e'(snp_type_i)), .snp_idx_i,
    .supply_o(snp_supply_o),
    .look_idx_i(head_idx), .look_st_o(line_st),
    .set_m_i(set_m), .set_idx_i(head_idx)
  );

  always_comb begin
    cm_d  = cm_q;
    rt_d  = rt_q;
    pop   = 1'b0;
    set_m = 1'b0;
    unique case (cm_q)
      CM_IDLE: if (head_ret) begin
        if (line_st == LS_M) pop = 1'b1;
        else begin
          cm_d = CM_WAIT;
          rt_d = (line_st == LS_S) ? REQ_UPG : REQ_RDX;
        end
      end
      CM_WAIT: if (bus_gnt_i) begin
        pop   = 1'b1;
        set_m = 1'b1;
        cm_d  = CM_IDLE;
      end
      default: cm_d = CM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cm_q <= CM_IDLE;
      rt_q <= REQ_UPG;
    end else begin
      cm_q <= cm_d;
      rt_q <= rt_d;
    end
  end

  assign st_ready_o     = !full;
  assign bus_req_o      = cm_q == CM_WAIT;
  assign bus_req_type_o = rt_q;
  assign bus_req_addr_o = head_addr;
  assign wr_en_o        = pop;
  assign wr_addr_o      = head_addr;
  assign wr_data_o      = head_data;

  // R1
  write_retired_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> head_ret);

  // R3
  local_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !bus_req_o |-> line_st == LS_M);

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_req_addr_o) && $stable(bus_req_type_o));

  // R6
  grant_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i |-> wr_en_o && wr_addr_o == bus_req_addr_o);
endmodule

// File: tb/stbuf_top_test.sv
`timescale 1ns/1ps
module stbuf_top_test;
  localparam int D  = 8;
  localparam int PW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic st_v = 0, ret = 0, fl = 0, snp_v = 0, snp_t = 0, gnt = 0;
  logic [31:0] st_a = 0, st_d = 0, ld_a = 0;
  logic [PW-1:0] ld_age = 0;
  logic [3:0] snp_i = 0;
  logic st_rdy, ld_hit, supply, breq, btype, wr_en;
  logic [PW-1:0] tag;
  logic [31:0] ld_d, baddr, wa, wd;

  stbuf_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_v), .st_addr_i(st_a), .st_data_i(st_d), .st_ready_o(st_rdy), .st_tag_o(tag),
    .retire_i(ret), .flush_i(fl),
    .ld_word_i(ld_a[31:2]), .ld_age_i(ld_age), .ld_hit_o(ld_hit), .ld_data_o(ld_d),
    .snp_valid_i(snp_v), .snp_type_i(snp_t), .snp_idx_i(snp_i), .snp_supply_o(supply),
    .bus_req_o(breq), .bus_req_type_o(btype), .bus_req_addr_o(baddr), .bus_gnt_i(gnt),
    .wr_en_o(wr_en), .wr_addr_o(wa), .wr_data_o(wd)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; bit r; } ent_t;
  ent_t q[$];
  int ls[16];
  int hptr = 0;
  bit wait_f = 0;
  bit wait_t = 0;
  int total = 0, bad = 0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int snext(int st, bit t);
    if (t) return 0;
    if (st == 2) return 1;
    return st;
  endfunction

  task automatic idle_in();
    st_v = 0; ret = 0; fl = 0; snp_v = 0; gnt = 0;
    ld_age = PW'(hptr + q.size());
  endtask

  // compare every output against the model, then advance both
  task automatic step();
    int used, span, eff, hidx;
    bit e_wr, e_hit, rdy, pop;
    logic [31:0] e_ld;
    used = q.size();
    rdy  = used < D;
    hidx = used > 0 ? int'(q[0].a[7:4]) : 0;
    eff  = ls[hidx];
    if (snp_v && int'(snp_i) == hidx) eff = snext(eff, snp_t);
    e_wr = 0;
    if (wait_f && gnt) e_wr = 1;
    else if (!wait_f && used > 0 && q[0].r && eff == 2) e_wr = 1;
    span = (int'(ld_age) - hptr) & (2*D-1);
    if (span > used) span = 0;
    e_hit = 0; e_ld = 0;
    for (int i = 0; i < span; i++)
      if (q[i].a[31:2] == ld_a[31:2]) begin e_hit = 1; e_ld = q[i].d; end
    #1;
    check(st_rdy == rdy, "R11 ready", st_rdy, rdy);
    check(tag == PW'(hptr + used), "R12 tag", tag, PW'(hptr + used));
    check(ld_hit == e_hit && (!e_hit || ld_d == e_ld), "R2/R9 forward", {ld_hit, ld_d}, {e_hit, e_ld});
    check(supply == (snp_v && ls[snp_i] == 2), "R7/R8 supply", supply, snp_v && ls[snp_i] == 2);
    check(breq == wait_f && (!wait_f || (btype == wait_t && baddr == q[0].a)), "R4/R5 request",
          {breq, btype, baddr}, {wait_f, wait_t, wait_f ? q[0].a : baddr});
    check(wr_en == e_wr && (!e_wr || (wa == q[0].a && wd == q[0].d)), "R1/R3/R6/R10 write",
          {wr_en, wd}, {e_wr, e_wr ? q[0].d : wd});
    @(posedge clk);
    if (snp_v) ls[snp_i] = snext(ls[snp_i], snp_t);
    pop = 0;
    if (wait_f && gnt) begin ls[hidx] = 2; pop = 1; wait_f = 0; end
    else if (!wait_f && used > 0 && q[0].r) begin
      if (eff == 2) pop = 1;
      else begin wait_f = 1; wait_t = (eff == 1) ? 1'b0 : 1'b1; end
    end
    if (ret)
      for (int i = 0; i < q.size(); i++) if (!q[i].r) begin q[i].r = 1; break; end
    if (pop) begin void'(q.pop_front()); hptr = (hptr + 1) % (2*D); end
    if (fl) begin
      while (q.size() > 0 && !q[q.size()-1].r) void'(q.pop_back());
    end else if (st_v && rdy) begin
      ent_t e; e.a = st_a; e.d = st_d; e.r = 0; q.push_back(e);
    end
    @(negedge clk);
  endtask

  task automatic store(logic [31:0] a, logic [31:0] d);
    idle_in(); st_v = 1; st_a = a; st_d = d; step();
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (ls[i]) ls[i] = 0;
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    // R13
    check(st_rdy && !breq && !wr_en && !ld_hit, "R13 reset", {st_rdy, breq, wr_en}, 3'b100);
    @(negedge clk);

    // invalid line: read-exclusive, then grant (R5, R6)
    store(32'h1014, 32'hAA);
    idle_in(); ret = 1; step();
    idle_in(); step();
    #0.5; check(breq && btype, "R5 rdx type", {breq, btype}, 2'b11);
    idle_in(); step();
    idle_in(); gnt = 1; #0.5; check(wr_en && wd == 32'hAA, "R6 grant write", {wr_en, wd}, {1'b1, 32'hAA});
    step();

    // buffered store, remote read hits M (R7), forwarding survives (R9), commit upgrades (R4)
    store(32'h1016, 32'hBB);
    idle_in(); snp_v = 1; snp_t = 0; snp_i = 4'h1; ld_a = 32'h1014;
    #0.5; check(supply && !wr_en, "R7 old data sourced", {supply, wr_en}, 2'b10);
    check(ld_hit && ld_d == 32'hBB, "R9 forward after snoop", ld_d, 32'hBB);
    step();
    idle_in(); ret = 1; step();
    idle_in(); step();
    #0.5; check(breq && !btype, "R4 upgrade type", {breq, btype}, 2'b10);
    idle_in(); step();
    idle_in(); gnt = 1; step();

    // local write on M (R3)
    store(32'h1010, 32'h11);
    idle_in(); ret = 1; step();
    idle_in(); #0.5; check(wr_en && !breq, "R3 local write", {wr_en, breq}, 2'b10);
    step();

    // R10 remote read-exclusive collides with commit decision
    store(32'h1010, 32'h22);
    idle_in(); ret = 1; step();
    idle_in(); snp_v = 1; snp_t = 1; snp_i = 4'h1;
    #0.5; check(!wr_en && supply, "R10 snoop first", {wr_en, supply}, 2'b01);
    step();
    idle_in(); #0.5; check(breq && btype, "R10 rdx after snoop", {breq, btype}, 2'b11);
    step();
    idle_in(); gnt = 1; snp_v = 1; snp_t = 1; snp_i = 4'h1; step();
    store(32'h1018, 32'h33);
    idle_in(); ret = 1; step();
    idle_in(); #0.5; check(wr_en, "R10 grant wins", wr_en, 1'b1);
    step();

    // R11 fill, extra store ignored; R12 flush keeps retired head
    for (int i = 0; i < D; i++) store(32'h2000 + 32'(i*4), 32'(i + 100));
    idle_in(); st_v = 1; st_a = 32'h2100; st_d = 32'h77;
    #0.5; check(!st_rdy, "R11 full", st_rdy, 1'b0);
    step();
    idle_in(); ret = 1; fl = 1; st_v = 1; st_a = 32'h2200; step();
    idle_in(); #0.5; check(tag == PW'(hptr + 1), "R12 flush tail", tag, PW'(hptr + 1));
    step();
    idle_in(); gnt = 1; step();
    idle_in(); step();

    // random phase
    for (int c = 0; c < 4000; c++) begin
      int sz;
      sz = q.size();
      idle_in();
      st_v = $urandom_range(0, 1);
      st_a = 32'h1000 + 32'($urandom_range(0, 2) << 4) + 32'($urandom_range(0, 15));
      st_d = $urandom;
      ld_a = 32'h1000 + 32'($urandom_range(0, 2) << 4) + 32'($urandom_range(0, 15));
      ld_age = ($urandom_range(0, 7) == 0) ? PW'(hptr + 2*D - 1) : PW'(hptr + $urandom_range(0, sz));
      snp_v = $urandom_range(0, 4) == 0;
      snp_t = $urandom_range(0, 1);
      snp_i = 4'($urandom_range(0, 2));
      gnt = $urandom_range(0, 2) == 0;
      ret = $urandom_range(0, 4) < 2;
      fl = $urandom_range(0, 39) == 0;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule